// File: doc/BRIEF.md
# Master-Gated Register Write Lock

This block is a small register bank for a memory protection unit. It decides per write whether the write may land. Each request arrives in a single cycle. It carries a master index that an upstream lookup has already decoded into 0 to 30, and a non-secure flag, which is bit 1 of the bus protection attribute. A lock bit selects the policy. While the lock is clear, every write lands. While it is set, a write to a guarded register lands only if the requester is secure and its enable bit is set in a 31-bit bypass mask.

Four interrupt-related registers stay writable by anyone in every lock state: the status, mask, enable and disable registers. Reads are never refused. A refused write leaves every register unchanged and returns an error in the same cycle. It also sets a sticky violation flag, which can raise the interrupt output.

Top module: `lockable_reg_bank`

## Requirements
- R1: While the lock bit is 0, every write from any master index (0 to 31), secure or not, lands and `rsp_err` stays 0.
- R2: While the lock bit is 1, a write to any address other than 2, 3, 4 or 5 lands only when `req_ns` is 0, `req_mid` is at most 30 and bypass-mask bit `req_mid` is 1. Any other such write is refused with `rsp_err` = 1. Index 31 has no enable bit.
- R3: A refused write leaves every register unchanged, and `rsp_err` is asserted in the same cycle as the request.
- R4: Writes to address 2 (status), 3 (interrupt mask), 4 (enable) and 5 (disable) are never refused, whatever the lock state, master or security flag.
- R5: Reads are never refused, and `rsp_rdata` returns the addressed register combinationally in the request cycle. Address 0 holds the lock in bit 0, address 1 the bypass mask, and addresses 6 to 7 two 32-bit configuration words.
- R6: After reset the lock is 0, the bypass mask reads 0x00000004, the configuration words are 0, the status is 0 and the interrupt mask is 0.
- R7: Bit 31 of the bypass mask always reads 0, and writes to it are ignored.
- R8: The lock register and the bypass mask are guarded registers under R2. While the lock is set, only an enabled secure master can change either of them or clear the lock.
- R9: A refused write sets status bit 0, and the bit stays set until a write of 1 to address 2 clears it. If a clear and a new violation fall in the same cycle, the clear wins.
- R10: Writing 1 to bit 0 of address 5 sets interrupt-mask bit 0. Writing 1 to bit 0 of address 4 clears it. A write to address 3 loads the mask directly. Addresses 4 and 5 read as 0.
- R11: `irq` is 1 exactly when status bit 0 is 1 and interrupt-mask bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register word address |
| req_wdata | input | 32 | Write data |
| req_mid | input | 5 | Decoded master index (31 = unknown) |
| req_ns | input | 1 | Protection attribute bit 1 (1 = non-secure) |
| rsp_rdata | output | 32 | Read data, same cycle |
| rsp_err | output | 1 | Write refused, same cycle |
| irq | output | 1 | Unmasked violation pending |

## Verification
With the lock open, every one of the 32 master indices is tried with both security values. A write that is wrongly refused for any master, or for either security value, shows up there. With the lock set, the same 64 combinations are run against a bypass mask with a mixed pattern, and the expected outcome is recomputed from the mask bit and the flag. This separates the security test from the mask lookup, and catches the out-of-range index 31 or the reserved bit being taken as an enable. Further single writes cover the following: the lock and mask guarding themselves; the four exempt registers being hit by an unenabled non-secure master; and the interrupt mask being driven three ways against a pending violation, so that the gating of `irq` is seen in both polarities.

// File: rtl/lrb_pkg.sv
// Package: shared constants for the lockable register bank.
// Assumes word addressing with a 4-bit address and a single violation status bit.
package lrb_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;
    localparam int MID_W  = 5;
    localparam int N_MST  = 31;   // master indices 0..N_MST-1 own an enable bit
    localparam int IRQ_W  = 1;    // bit 0 = write violation

    localparam logic [ADDR_W-1:0] A_LOCK = 4'd0;
    localparam logic [ADDR_W-1:0] A_BYP  = 4'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd2;
    localparam logic [ADDR_W-1:0] A_IMSK = 4'd3;
    localparam logic [ADDR_W-1:0] A_IEN  = 4'd4;
    localparam logic [ADDR_W-1:0] A_IDIS = 4'd5;
    localparam logic [ADDR_W-1:0] A_CFG0 = 4'd6;

    localparam logic [N_MST-1:0] BYP_RESET = 31'h0000_0004;
endpackage

// File: rtl/lrb_perm.sv
// Module: write-permission check.
// Decides whether the current write may land. Exempt registers and an open lock
// always pass. Otherwise the requester must be secure and enabled in the bypass mask.
// Assumes the master index is already decoded; indices at or above N_MST have no bit.
module lrb_perm
    import lrb_pkg::*;
(
    input  logic             lock,
    input  logic [N_MST-1:0] byp_mask,
    input  logic [MID_W-1:0] mid,
    input  logic             nonsec,
    input  logic             exempt,
    output logic             allow
);
    logic mid_in_range;
    logic mid_enabled;

    // Look up the requester's enable bit, treating out-of-range indices as disabled.
    always_comb begin
        mid_in_range = (mid < MID_W'(N_MST));
        mid_enabled  = mid_in_range && byp_mask[mid];
    end

    // Combine lock state, exemption, security flag and enable bit.
    always_comb begin
        allow = exempt || !lock || (!nonsec && mid_enabled);
    end
endmodule

// File: rtl/lrb_irq.sv
// Module: violation status, interrupt mask and interrupt output.
// The status bits are sticky and cleared by writing 1 (the clear wins over a
// same-cycle set). The mask is loaded directly, set through the disable register
// and cleared through the enable register. Assumes that the write strobes are already
// qualified by valid/write/address.
module lrb_irq
    import lrb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             viol,
    input  logic             stat_wr,
    input  logic             imsk_wr,
    input  logic             ien_wr,
    input  logic             idis_wr,
    input  logic [IRQ_W-1:0] wbits,
    output logic [IRQ_W-1:0] stat,
    output logic [IRQ_W-1:0] imsk,
    output logic             irq
);
    logic [IRQ_W-1:0] set_v;
    logic [IRQ_W-1:0] clr_v;

    // Build the set and clear vectors for the status register.
    always_comb begin
        set_v    = '0;
        set_v[0] = viol;
        clr_v    = stat_wr ? wbits : '0;
    end

    // Status register: sticky set, clear by writing 1, clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat | set_v) & ~clr_v;
    end

    // Mask register: direct load, set through the disable register, clear through the enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)       imsk <= '0;
        else if (imsk_wr) imsk <= wbits;
        else if (idis_wr) imsk <= imsk | wbits;
        else if (ien_wr)  imsk <= imsk & ~wbits;
    end

    // Interrupt is raised when any unmasked status bit is pending.
    always_comb begin
        irq = |(stat & ~imsk);
    end
endmodule

// File: rtl/lockable_reg_bank.sv
// Module: lockable register bank (top).
// Holds the lock bit, the bypass mask and NUM_CFG guarded configuration words.
// Every write passes through lrb_perm; refused writes raise rsp_err and a
// violation in lrb_irq. Reads are combinational and never refused.
// Assumes a single-cycle request and a pre-decoded master index.
module lockable_reg_bank
    import lrb_pkg::*;
#(
    parameter int NUM_CFG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [MID_W-1:0]  req_mid,
    input  logic              req_ns,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              irq
);
    localparam int CFG_FLAT_W = NUM_CFG * DATA_W;

    logic                  lock_q;
    logic [N_MST-1:0]      mask_q;
    logic [CFG_FLAT_W-1:0] cfg_flat;
    logic [IRQ_W-1:0]      stat_q;
    logic [IRQ_W-1:0]      imsk_q;
    logic                  wr_req;
    logic                  exempt;
    logic                  allow;
    logic                  wr_ok;

    // Classify the request: is it a write, and does it target an exempt register?
    always_comb begin
        wr_req = req_valid && req_write;
        exempt = (req_addr == A_STAT) || (req_addr == A_IMSK) ||
                 (req_addr == A_IEN)  || (req_addr == A_IDIS);
    end

    lrb_perm u_perm (
        .lock     (lock_q),
        .byp_mask (mask_q),
        .mid      (req_mid),
        .nonsec   (req_ns),
        .exempt   (exempt),
        .allow    (allow)
    );

    // Final write enable and same-cycle error response.
    always_comb begin
        wr_ok   = wr_req && allow;
        rsp_err = wr_req && !allow;
    end

    // Lock register: bit 0 is the write-disable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                          lock_q <= 1'b0;
        else if (wr_ok && req_addr == A_LOCK) lock_q <= req_wdata[0];
    end

    // Bypass mask: only the implemented bits are stored; bit 31 is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)                          mask_q <= BYP_RESET;
        else if (wr_ok && req_addr == A_BYP) mask_q <= req_wdata[N_MST-1:0];
    end

    // Guarded configuration words, one register per generated slot.
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(A_CFG0) + g);
        // Load this configuration word when a permitted write addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n)                           cfg_flat[g*DATA_W +: DATA_W] <= '0;
            else if (wr_ok && req_addr == MY_ADDR) cfg_flat[g*DATA_W +: DATA_W] <= req_wdata;
        end
    end

    lrb_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .viol    (rsp_err),
        .stat_wr (wr_ok && req_addr == A_STAT),
        .imsk_wr (wr_ok && req_addr == A_IMSK),
        .ien_wr  (wr_ok && req_addr == A_IEN),
        .idis_wr (wr_ok && req_addr == A_IDIS),
        .wbits   (req_wdata[IRQ_W-1:0]),
        .stat    (stat_q),
        .imsk    (imsk_q),
        .irq     (irq)
    );

    // Read-back multiplexer; enable/disable and unmapped addresses read as zero.
    always_comb begin
        rsp_rdata = '0;
        case (req_addr)
            A_LOCK:  rsp_rdata[0]          = lock_q;
            A_BYP:   rsp_rdata[N_MST-1:0]  = mask_q;
            A_STAT:  rsp_rdata[IRQ_W-1:0]  = stat_q;
            A_IMSK:  rsp_rdata[IRQ_W-1:0]  = imsk_q;
            default: begin
                for (int i = 0; i < NUM_CFG; i++) begin
                    if (req_addr == ADDR_W'(int'(A_CFG0) + i))
                        rsp_rdata = cfg_flat[i*DATA_W +: DATA_W];
                end
            end
        endcase
    end
endmodule

// File: rtl/lrb_checker.sv
// Module: assertion checker for lockable_reg_bank, attached through bind.
// Observes ports and the stored register state; drives nothing.
module lrb_checker
    import lrb_pkg::*;
#(
    parameter int NUM_CFG = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_write,
    input logic [ADDR_W-1:0]        req_addr,
    input logic [DATA_W-1:0]        req_wdata,
    input logic                     rsp_err,
    input logic                     irq,
    input logic                     lock_q,
    input logic [N_MST-1:0]         mask_q,
    input logic [NUM_CFG*DATA_W-1:0] cfg_flat,
    input logic [IRQ_W-1:0]         stat_q,
    input logic [IRQ_W-1:0]         imsk_q
);
    logic stat_clear;
    assign stat_clear = req_valid && req_write && req_addr == A_STAT && req_wdata[0];

    a_r1_open_lock_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_q && req_valid) |-> !rsp_err);

    a_r3_blocked_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |=> ($stable(lock_q) && $stable(mask_q) && $stable(cfg_flat) && $stable(imsk_q)));

    a_r4_exempt_never_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr >= A_STAT && req_addr <= A_IDIS) |-> !rsp_err);

    a_r5_read_never_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> !rsp_err);

    a_r9_violation_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |=> stat_q[0]);

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clear |=> !stat_q[0]);

    a_r9_holds_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[0] && !stat_clear) |=> stat_q[0]);

    a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (imsk_q[0] || !stat_q[0]) |-> !irq);
endmodule

bind lockable_reg_bank lrb_checker #(.NUM_CFG(NUM_CFG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_err   (rsp_err),
    .irq       (irq),
    .lock_q    (lock_q),
    .mask_q    (mask_q),
    .cfg_flat  (cfg_flat),
    .stat_q    (stat_q),
    .imsk_q    (imsk_q)
);

// File: tb/lockable_reg_bank_tb.sv
// Bench: sweeps every master index and security value in both lock states and
// computes each expected outcome from the bypass-mask pattern.
module lockable_reg_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [4:0]  req_mid = '0;
    logic        req_ns = 1'b0;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic        got_err;
    logic [31:0] got_rd;
    logic        got_irq;

    always #5 clk = ~clk;

    lockable_reg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mid(req_mid), .req_ns(req_ns),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [3:0] a, input logic [31:0] d,
                       input logic [4:0] m, input logic ns);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        req_mid = m; req_ns = ns;
        #1;
        got_err = rsp_err; got_rd = rsp_rdata; got_irq = irq;
        @(posedge clk);
        #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        acc(1'b0, a, 32'h0, 5'd31, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] me;
        logic [31:0] cur;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R6 reset state
        rd(4'd0); check("R6 lock", got_rd, 32'h0);
        check("R5 read err", {31'b0, got_err}, 32'h0);
        rd(4'd1); check("R6 mask", got_rd, 32'h4);
        rd(4'd6); check("R6 cfg0", got_rd, 32'h0);
        rd(4'd7); check("R6 cfg1", got_rd, 32'h0);
        rd(4'd2); check("R6 stat", got_rd, 32'h0);
        rd(4'd3); check("R6 imsk", got_rd, 32'h0);
        check("R6 irq", {31'b0, got_irq}, 32'h0);

        // R7 reserved mask bit
        acc(1'b1, 4'd1, 32'hFFFF_FFFF, 5'd20, 1'b1);
        rd(4'd1); check("R7 bit31", got_rd, 32'h7FFF_FFFF);

        // R1 open lock sweep
        for (int m = 0; m < 32; m++) begin
            for (int n = 0; n < 2; n++) begin
                logic [31:0] d;
                d = 32'h1000_0000 | (m << 8) | n;
                acc(1'b1, 4'd6, d, 5'(m), 1'(n));
                check("R1 err", {31'b0, got_err}, 32'h0);
                rd(4'd6); check("R1 data", got_rd, d);
            end
        end

        // Load mixed mask, then lock
        acc(1'b1, 4'd1, 32'hA5A5_0F0F, 5'd31, 1'b1);
        me = 32'hA5A5_0F0F & 32'h7FFF_FFFF;
        rd(4'd1); check("R7 mask", got_rd, me);
        acc(1'b1, 4'd0, 32'h1, 5'd31, 1'b1);
        rd(4'd0); check("R1 lock set", got_rd, 32'h1);

        // R2/R3/R9/R11 locked sweep
        cur = 32'h0;
        for (int m = 0; m < 32; m++) begin
            for (int n = 0; n < 2; n++) begin
                logic [31:0] d;
                logic ok;
                d  = 32'h5000_0000 | (m << 4) | n;
                ok = (n == 0) && (m < 31) && me[m];
                acc(1'b1, 4'd7, d, 5'(m), 1'(n));
                check("R2 err", {31'b0, got_err}, {31'b0, !ok});
                rd(4'd7);
                if (ok) cur = d;
                check("R3 data", got_rd, cur);
                rd(4'd2); check("R9 stat", got_rd, {31'b0, !ok});
                check("R11 irq", {31'b0, got_irq}, {31'b0, !ok});
                if (!ok) begin
                    acc(1'b1, 4'd2, 32'h1, 5'd31, 1'b1);
                    check("R4 stat write", {31'b0, got_err}, 32'h0);
                    rd(4'd2); check("R9 clear", got_rd, 32'h0);
                end
            end
        end

        // R8 lock and mask are guarded
        acc(1'b1, 4'd0, 32'h0, 5'd31, 1'b0);
        check("R8 lock err", {31'b0, got_err}, 32'h1);
        rd(4'd0); check("R8 lock kept", got_rd, 32'h1);
        acc(1'b1, 4'd1, 32'h0, 5'd0, 1'b1);
        check("R8 mask err", {31'b0, got_err}, 32'h1);
        rd(4'd1); check("R8 mask kept", got_rd, me);
        acc(1'b1, 4'd1, 32'h0000_0001, 5'd0, 1'b0);
        check("R8 mask ok", {31'b0, got_err}, 32'h0);
        rd(4'd1); check("R8 mask new", got_rd, 32'h1);
        acc(1'b1, 4'd2, 32'h1, 5'd31, 1'b1);

        // R10/R11 interrupt mask control
        acc(1'b1, 4'd5, 32'h1, 5'd31, 1'b1);
        check("R4 idis err", {31'b0, got_err}, 32'h0);
        rd(4'd3); check("R10 idis sets", got_rd, 32'h1);
        rd(4'd4); check("R10 ien reads 0", got_rd, 32'h0);
        rd(4'd5); check("R10 idis reads 0", got_rd, 32'h0);
        acc(1'b1, 4'd6, 32'hDEAD_0000, 5'd31, 1'b1);
        check("R2 viol", {31'b0, got_err}, 32'h1);
        rd(4'd2); check("R9 stat set", got_rd, 32'h1);
        check("R11 masked", {31'b0, got_irq}, 32'h0);
        acc(1'b1, 4'd4, 32'h1, 5'd31, 1'b1);
        check("R4 ien err", {31'b0, got_err}, 32'h0);
        rd(4'd3); check("R10 ien clears", got_rd, 32'h0);
        check("R11 unmasked", {31'b0, got_irq}, 32'h1);
        acc(1'b1, 4'd3, 32'h1, 5'd31, 1'b1);
        check("R4 imsk err", {31'b0, got_err}, 32'h0);
        rd(4'd3); check("R10 imsk load", got_rd, 32'h1);
        check("R11 remasked", {31'b0, got_irq}, 32'h0);
        acc(1'b1, 4'd2, 32'h1, 5'd31, 1'b1);
        rd(4'd2); check("R9 clear2", got_rd, 32'h0);

        // R8 enabled secure master unlocks, then R1 again
        acc(1'b1, 4'd0, 32'h0, 5'd0, 1'b0);
        check("R8 unlock err", {31'b0, got_err}, 32'h0);
        rd(4'd0); check("R8 unlocked", got_rd, 32'h0);
        acc(1'b1, 4'd6, 32'h1234_5678, 5'd31, 1'b1);
        check("R1 reopen err", {31'b0, got_err}, 32'h0);
        rd(4'd6); check("R1 reopen data", got_rd, 32'h1234_5678);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule